// File: doc/BRIEF.md
# Cascadable Linear Sensor Scan Sequencer

This block sequences the readout of one die in a chain of linear image sensor dies that share a single video line. On each clock it says which of its pixels, if any, is placed on the shared line, whether this die drives that line, whether its output amplifier is powered, and when its scan is about to end. Each edge of `clk` stands for the falling clock edge on which a real die loads its start inputs. All state changes on that edge.

A strap input sets the role of the die. With the strap high the die heads the chain. A sampled global start opens a lead-in of 29 idle cycles, and the first pixel then appears in the 30th cycle. With the strap low the die waits for its local start, which is wired to the end-of-scan output of the die before it. It then shows its first pixel one cycle after that start is sampled. End-of-scan is raised during the second-to-last pixel. The next die therefore samples it one cycle early and follows with no gap.

A start sampled while the die is in its lead-in or scan restarts the sequence from the beginning. A start held high across two edges is therefore loaded twice, and the sequence runs from the second load.

Top module: `lin_scan_seq`

## Requirements
- R1: While `rst` is high at an edge, every output is low after that edge and the die is idle.
- R2: With `first_die`=1, a `gstart` sampled high at edge E0 leaves `pix_sel` all zero through edge E0+28. Bit 0 of `pix_sel` is set after edge E0+29.
- R3: Once a scan starts, `pix_sel` is one-hot and walks from bit 0 to bit 343, one bit per clock. It is all zero after the edge that follows bit 343. At no time is more than one bit set.
- R4: With `first_die`=0, an `lstart` sampled high at edge E0 sets bit 0 of `pix_sel` after edge E0+1.
- R5: `eos` is high for exactly the one cycle in which bit 342 of `pix_sel` (pixel 343) is set.
- R6: A die with `first_die`=1 ignores `lstart`. A die with `first_die`=0 ignores `gstart`.
- R7: `vid_en` is high exactly in the cycles in which some bit of `pix_sel` is set.
- R8: After each edge with `rst` low, `amp_en` equals the value `first_die` had at that edge. A chained die keeps it low.
- R9: A start sampled during the lead-in or the scan restarts timing from that edge. A start held high for two edges is loaded at both edges, so timing counts from the second one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock; each edge is a start-sampling edge |
| rst | input | 1 | Synchronous active-high reset |
| gstart | input | 1 | Global start, used when `first_die` is high |
| lstart | input | 1 | Local start from the previous die, used when `first_die` is low |
| first_die | input | 1 | Strap: 1 = head of chain, 0 = chained die |
| pix_sel | output | 344 | One-hot select of the pixel on the shared video line |
| vid_en | output | 1 | This die drives the shared video line |
| amp_en | output | 1 | Output amplifier power enable |
| eos | output | 1 | End-of-scan pulse for the next die |

## Verification
A corrupted lead-in count moves the first pixel off the 30th cycle, and the error is visible in the first cycle in which `pix_sel` should rise. A wrong pixel index shows up at once as a skipped or repeated select bit. It can also show as an `eos` that is not followed by bit 343, which would break the handoff to the next die in the very next cycle. A stuck scan state leaves `vid_en` high past the 344th pixel, so two dies would drive the line together one cycle after this one should have stopped.

// File: rtl/lin_scan_seq.sv
module lin_scan_seq #(
  parameter int NPIX = 344,
  parameter int LEAD = 29
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gstart,
  input  logic            lstart,
  input  logic            first_die,
  output logic [NPIX-1:0] pix_sel,
  output logic            vid_en,
  output logic            amp_en,
  output logic            eos
);
  localparam int IW = $clog2(NPIX);
  localparam int CW = $clog2(LEAD + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SCAN} st_t;

  st_t           st;
  logic [CW-1:0] lcnt;
  logic [IW-1:0] idx;
  logic          go;

  assign go = first_die ? gstart : lstart;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      lcnt   <= '0;
      idx    <= '0;
      amp_en <= 1'b0;
    end else begin
      amp_en <= first_die;
      if (go) begin
        st   <= ST_LEAD;
        lcnt <= first_die ? CW'(1) : CW'(LEAD);
      end else begin
        case (st)
          ST_LEAD:
            if (lcnt == CW'(LEAD)) begin
              st  <= ST_SCAN;
              idx <= '0;
            end else begin
              lcnt <= lcnt + 1'b1;
            end
          ST_SCAN:
            if (idx == IW'(NPIX - 1)) st <= ST_IDLE;
            else idx <= idx + 1'b1;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign vid_en = (st == ST_SCAN);
  assign eos    = (st == ST_SCAN) && (idx == IW'(NPIX - 2));

  for (genvar i = 0; i < NPIX; i++) begin : g_sel
    assign pix_sel[i] = (st == ST_SCAN) && (idx == IW'(i));
  end
endmodule

// File: rtl/lin_scan_seq_chk.sv
module lin_scan_seq_chk #(
  parameter int NPIX = 344
) (
  input logic            clk,
  input logic            rst,
  input logic            gstart,
  input logic            lstart,
  input logic            first_die,
  input logic [NPIX-1:0] pix_sel,
  input logic            vid_en,
  input logic            amp_en,
  input logic            eos
);
  logic go_in;
  assign go_in = first_die ? gstart : lstart;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (pix_sel == '0 && !vid_en && !eos && !amp_en)); // R1
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(pix_sel)); // R3
  AST_SEL_WALK: assert property (@(posedge clk) disable iff (rst) (pix_sel[0] && !go_in) |=> pix_sel[1]); // R3
  AST_EOS_HANDOFF: assert property (@(posedge clk) disable iff (rst) (eos && !go_in) |=> pix_sel[NPIX-1]); // R5
  AST_EOS_SINGLE: assert property (@(posedge clk) disable iff (rst) eos |=> !eos); // R5
  AST_EOS_ON_SEL: assert property (@(posedge clk) disable iff (rst) eos |-> pix_sel[NPIX-2]); // R5
  AST_VID_HAS_SEL: assert property (@(posedge clk) disable iff (rst) vid_en |-> (pix_sel != '0)); // R7
  AST_SEL_HAS_VID: assert property (@(posedge clk) disable iff (rst) (pix_sel != '0) |-> vid_en); // R7
  AST_AMP_CHAIN_OFF: assert property (@(posedge clk) disable iff (rst) !first_die |=> !amp_en); // R8
endmodule

bind lin_scan_seq lin_scan_seq_chk #(.NPIX(NPIX)) u_chk (
  .clk(clk), .rst(rst), .gstart(gstart), .lstart(lstart), .first_die(first_die),
  .pix_sel(pix_sel), .vid_en(vid_en), .amp_en(amp_en), .eos(eos)
);

// File: tb/tb_lin_scan_seq.sv
module tb_lin_scan_seq;
  localparam int NPIX = 344;
  localparam int LEAD = 29;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            gstart = 1'b0;
  logic            lstart = 1'b0;
  logic            first_die = 1'b1;
  logic [NPIX-1:0] pix_sel;
  logic            vid_en, amp_en, eos;

  int    errors = 0;
  int    checks = 0;
  int    k = -1;
  logic  amp_exp = 1'b0;
  string tag = "R1";

  always #4 clk = ~clk;

  lin_scan_seq #(.NPIX(NPIX), .LEAD(LEAD)) dut (
    .clk(clk), .rst(rst), .gstart(gstart), .lstart(lstart), .first_die(first_die),
    .pix_sel(pix_sel), .vid_en(vid_en), .amp_en(amp_en), .eos(eos)
  );

  function automatic int delay_of(logic strap);
    return strap ? LEAD : 1;
  endfunction

  function automatic int pix_idx(int kk, logic strap);
    if (kk < 0) return -1;
    if (kk - delay_of(strap) < 0 || kk - delay_of(strap) > NPIX - 1) return -1;
    return kk - delay_of(strap);
  endfunction

  task automatic chk(logic ok, string req, string what, logic [NPIX-1:0] act, logic [NPIX-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(logic r, logic gs, logic ls);
    logic hit;
    int   ix;
    logic [NPIX-1:0] pexp;
    @(negedge clk);
    rst = r; gstart = gs; lstart = ls;
    @(posedge clk);
    hit = first_die ? gs : ls;
    if (r) k = -1;
    else if (hit) k = 0;
    else if (k >= 0 && k < delay_of(first_die) + NPIX - 1) k++;
    else k = -1;
    amp_exp = r ? 1'b0 : first_die;
    #2;
    ix = pix_idx(k, first_die);
    pexp = (ix >= 0) ? (NPIX'(1) << ix) : '0;
    chk(pix_sel == pexp, r ? "R1" : tag, "pix_sel", pix_sel, pexp);
    chk($countones(pix_sel) <= 1, "R3", "one-hot", NPIX'($countones(pix_sel)), NPIX'(1));
    chk(vid_en == (ix >= 0), r ? "R1" : "R7", "vid_en", NPIX'(vid_en), NPIX'(ix >= 0));
    chk(eos == (ix == NPIX - 2), r ? "R1" : "R5", "eos", NPIX'(eos), NPIX'(ix == NPIX - 2));
    chk(amp_en == amp_exp, r ? "R1" : "R8", "amp_en", NPIX'(amp_en), NPIX'(amp_exp));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_reset(logic strap);
    first_die = strap;
    tag = "R1";
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240611));

    do_reset(1'b1);
    tag = "R2";
    step(1'b0, 1'b1, 1'b0);
    idle(380);

    tag = "R6";
    step(1'b0, 1'b0, 1'b1);
    idle(40);
    do_reset(1'b0);
    tag = "R6";
    step(1'b0, 1'b1, 1'b0);
    idle(40);

    tag = "R4";
    step(1'b0, 1'b0, 1'b1);
    idle(350);

    tag = "R9";
    step(1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b1);
    idle(100);
    step(1'b0, 1'b0, 1'b1);
    idle(360);
    do_reset(1'b1);
    tag = "R9";
    step(1'b0, 1'b1, 1'b0);
    idle(10);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    idle(200);
    step(1'b0, 1'b1, 1'b0);
    idle(380);

    for (int seg = 0; seg < 6; seg++) begin
      do_reset(1'($urandom % 2));
      tag = "R3";
      for (int c = 0; c < 1500; c++) begin
        logic main_go, noise;
        main_go = ($urandom % 300) == 0;
        noise   = ($urandom % 50) == 0;
        if (first_die) step(1'b0, main_go, noise);
        else           step(1'b0, noise, main_go);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule